// File: doc/BRIEF.md
# Microcontroller 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style microcontroller. Each cycle it takes the working register value, a second operand, and a 4-bit operation code. The second operand is either a register-file byte or an 8-bit literal. From these it forms an 8-bit result and says where that result goes: back to the working register, or to the register-file location it came from. It also keeps three status flags (zero, carry, digit carry) in a small register. Rotates read the stored carry flag as their carry-in.

Each operation changes only its own group of flags. The per-flag write enables are driven on the outputs, so the rest of the datapath can see which flags the current operation touches. On subtraction the carry and digit-carry flags mean "no borrow", and the operand order is register minus working register. Fetch, decode, the register file itself and the other status bits belong to other blocks.

Top module: `mcu_alu8`

## Requirements
- R1: Operation codes 0 (AND), 1 (inclusive OR) and 2 (exclusive OR) combine W with the selected operand. Code 3 returns the ones complement of the selected operand and ignores W.
- R2: Code 4 returns W plus the operand modulo 256. It sets C to the carry out of bit 7 and DC to the carry out of bit 3.
- R3: Code 5 returns the operand minus W modulo 256. C is 1 when the operand is at least W. DC is 1 when the operand's low nibble is at least W's low nibble.
- R4: Code 6 returns the operand plus one and code 7 the operand minus one, both wrapping at 8 bits.
- R5: Codes 0 to 7 load Z with 1 exactly when the 8-bit result is zero.
- R6: Code 8 rotates the operand left through the stored C and code 9 rotates it right through the stored C. The bit shifted out is loaded into C and the old C enters at the other end.
- R7: Code 10 exchanges the two 4-bit halves of the operand and leaves all three flags unchanged.
- R8: The operand is `lit_in` when `use_lit` is 1 and `f_in` otherwise. `dest_is_reg` equals `dest_reg` for a register operand and is always 0 for a literal operand.
- R9: The flag write enables are `flag_we[0]` for Z, `flag_we[1]` for C and `flag_we[2]` for DC. They are 001 for codes 0, 1, 2, 3, 6 and 7, 111 for codes 4 and 5, 010 for codes 8 and 9, and 000 otherwise. On each clock edge only the enabled flags change.
- R10: A synchronous reset clears Z, C and DC, and takes priority over any operation in the same cycle.
- R11: Codes 11 to 15 return the operand unchanged and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Operation code |
| use_lit | input | 1 | Select the literal as operand |
| dest_reg | input | 1 | Destination bit for register operands |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Register-file operand |
| lit_in | input | 8 | Literal operand |
| result | output | 8 | Operation result |
| dest_is_reg | output | 1 | 1 = write result to register file, 0 = to W |
| flag_we | output | 3 | Flag write enables {DC, C, Z} |
| stat_z | output | 1 | Stored zero flag |
| stat_c | output | 1 | Stored carry / no-borrow flag |
| stat_dc | output | 1 | Stored digit carry / no-borrow flag |

## Verification
The bench runs several kinds of sequence in order:
- Subtractions where the operand is above, equal to and below W, and where only the low nibble borrows. A design that computed W minus the operand, or stored carry as borrow, would show an inverted C or DC.
- Rotates with a zero result, right after a Z-setting operation. This catches a design that let rotates update Z.
- A complement that follows an add which set C and DC. This catches flags that the complement should not touch being overwritten.
- Literal operations with the destination bit set, and reset asserted together with a flag-setting add. These show a misrouted destination, or an operation winning over reset.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_IOR = 4'd1,
        OP_XOR = 4'd2,
        OP_COM = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_INC = 4'd6,
        OP_DEC = 4'd7,
        OP_RLC = 4'd8,
        OP_RRC = 4'd9,
        OP_SWP = 4'd10
    } alu_op_e;

    localparam int FLAG_N  = 3;
    localparam int FL_Z    = 0;
    localparam int FL_C    = 1;
    localparam int FL_DC   = 2;

    typedef logic [FLAG_N-1:0] flag_vec_t;

endpackage

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] res,
    output logic             hit
);
    always_comb begin
        res = '0;
        hit = 1'b1;
        case (op)
            OP_AND:  res = acc & opnd;
            OP_IOR:  res = acc | opnd;
            OP_XOR:  res = acc ^ opnd;
            OP_COM:  res = ~opnd;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] res,
    output logic             carry,
    output logic             dcarry,
    output logic             hit,
    output logic             cy_hit
);
    localparam logic [WIDTH-1:0] ONE_W   = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH:0]   ONE_W1  = {{WIDTH{1'b0}}, 1'b1};
    localparam logic [DIGIT:0]   ONE_D1  = {{DIGIT{1'b0}}, 1'b1};

    logic [WIDTH:0] add_full;
    logic [WIDTH:0] sub_full;
    logic [DIGIT:0] add_lo;
    logic [DIGIT:0] sub_lo;

    always_comb begin
        add_full = {1'b0, acc} + {1'b0, opnd};
        add_lo   = {1'b0, acc[DIGIT-1:0]} + {1'b0, opnd[DIGIT-1:0]};
        sub_full = {1'b0, opnd} + {1'b0, ~acc} + ONE_W1;
        sub_lo   = {1'b0, opnd[DIGIT-1:0]} + {1'b0, ~acc[DIGIT-1:0]} + ONE_D1;

        res    = '0;
        carry  = 1'b0;
        dcarry = 1'b0;
        hit    = 1'b1;
        cy_hit = 1'b0;
        case (op)
            OP_ADD: begin
                res    = add_full[WIDTH-1:0];
                carry  = add_full[WIDTH];
                dcarry = add_lo[DIGIT];
                cy_hit = 1'b1;
            end
            OP_SUB: begin
                res    = sub_full[WIDTH-1:0];
                carry  = sub_full[WIDTH];
                dcarry = sub_lo[DIGIT];
                cy_hit = 1'b1;
            end
            OP_INC:  res = opnd + ONE_W;
            OP_DEC:  res = opnd - ONE_W;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_rot_unit.sv
module alu8_rot_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opnd,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             rot_hit,
    output logic             swp_hit
);
    localparam int HALF = WIDTH / 2;

    always_comb begin
        res     = '0;
        cout    = 1'b0;
        rot_hit = 1'b0;
        swp_hit = 1'b0;
        case (op)
            OP_RLC: begin
                res     = {opnd[WIDTH-2:0], cin};
                cout    = opnd[WIDTH-1];
                rot_hit = 1'b1;
            end
            OP_RRC: begin
                res     = {cin, opnd[WIDTH-1:1]};
                cout    = opnd[0];
                rot_hit = 1'b1;
            end
            OP_SWP: begin
                res     = {opnd[HALF-1:0], opnd[WIDTH-1:HALF]};
                swp_hit = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mcu_alu8.sv
module mcu_alu8
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_sel,
    input  logic             use_lit,
    input  logic             dest_reg,
    input  logic [WIDTH-1:0] w_in,
    input  logic [WIDTH-1:0] f_in,
    input  logic [WIDTH-1:0] lit_in,
    output logic [WIDTH-1:0] result,
    output logic             dest_is_reg,
    output logic [2:0]       flag_we,
    output logic             stat_z,
    output logic             stat_c,
    output logic             stat_dc
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             to_reg;
        flag_vec_t        we;
        flag_vec_t        val;
    } alu_comb_t;

    logic [WIDTH-1:0] opnd;
    logic [WIDTH-1:0] lg_res, ar_res, rt_res;
    logic             lg_hit, ar_hit, ar_cy_hit, rt_hit, sw_hit;
    logic             ar_c, ar_dc, rt_c;

    alu_comb_t comb_d;
    flag_vec_t st_d, st_q;

    assign opnd = use_lit ? lit_in : f_in;

    alu8_logic_unit #(.WIDTH(WIDTH)) i_logic (
        .op   (op_sel),
        .acc  (w_in),
        .opnd (opnd),
        .res  (lg_res),
        .hit  (lg_hit)
    );

    alu8_arith_unit #(.WIDTH(WIDTH), .DIGIT(DIGIT)) i_arith (
        .op     (op_sel),
        .acc    (w_in),
        .opnd   (opnd),
        .res    (ar_res),
        .carry  (ar_c),
        .dcarry (ar_dc),
        .hit    (ar_hit),
        .cy_hit (ar_cy_hit)
    );

    alu8_rot_unit #(.WIDTH(WIDTH)) i_rot (
        .op      (op_sel),
        .opnd    (opnd),
        .cin     (st_q[FL_C]),
        .res     (rt_res),
        .cout    (rt_c),
        .rot_hit (rt_hit),
        .swp_hit (sw_hit)
    );

    // Next-value process: result, routing, flag values and enables.
    always_comb begin
        comb_d        = '0;
        comb_d.res    = opnd;
        comb_d.to_reg = dest_reg & ~use_lit;
        if (lg_hit) begin
            comb_d.res        = lg_res;
            comb_d.we[FL_Z]   = 1'b1;
        end else if (ar_hit) begin
            comb_d.res        = ar_res;
            comb_d.we[FL_Z]   = 1'b1;
            comb_d.we[FL_C]   = ar_cy_hit;
            comb_d.we[FL_DC]  = ar_cy_hit;
            comb_d.val[FL_C]  = ar_c;
            comb_d.val[FL_DC] = ar_dc;
        end else if (rt_hit) begin
            comb_d.res        = rt_res;
            comb_d.we[FL_C]   = 1'b1;
            comb_d.val[FL_C]  = rt_c;
        end else if (sw_hit) begin
            comb_d.res        = rt_res;
        end
        comb_d.val[FL_Z] = (comb_d.res == '0);
    end

    // Per-flag selective update.
    for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
        always_comb begin
            st_d[k] = comb_d.we[k] ? comb_d.val[k] : st_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result      = comb_d.res;
    assign dest_is_reg = comb_d.to_reg;
    assign flag_we     = comb_d.we;
    assign stat_z      = st_q[FL_Z];
    assign stat_c      = st_q[FL_C];
    assign stat_dc     = st_q[FL_DC];

endmodule

module mcu_alu8_chk
    import alu8_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] op_sel,
    input logic       use_lit,
    input logic [7:0] f_in,
    input logic [7:0] lit_in,
    input logic [7:0] result,
    input logic       dest_is_reg,
    input logic [2:0] flag_we,
    input logic       stat_z,
    input logic       stat_c,
    input logic       stat_dc
);
    // R8
    lit_dest_chk: assert property (@(posedge clk) disable iff (rst)
        use_lit |-> !dest_is_reg);

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we[0] |=> (stat_z == ($past(result) == 8'h00)));

    // R6
    rot_left_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_RLC) |=> (stat_c == $past(use_lit ? lit_in[7] : f_in[7])));

    // R6
    rot_right_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_RRC) |=> (stat_c == $past(use_lit ? lit_in[0] : f_in[0])));

    // R7
    swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SWP) |=> $stable({stat_z, stat_c, stat_dc}));

    // R9
    carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we[1] |=> $stable(stat_c));

    // R9
    dc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we[2] |=> $stable(stat_dc));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!stat_z && !stat_c && !stat_dc));
endmodule

bind mcu_alu8 mcu_alu8_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .op_sel      (op_sel),
    .use_lit     (use_lit),
    .f_in        (f_in),
    .lit_in      (lit_in),
    .result      (result),
    .dest_is_reg (dest_is_reg),
    .flag_we     (flag_we),
    .stat_z      (stat_z),
    .stat_c      (stat_c),
    .stat_dc     (stat_dc)
);

// File: tb/test_mcu_alu8.sv
module test_mcu_alu8;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 23;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = '0;
    logic       use_lit = 1'b0;
    logic       dest_reg = 1'b0;
    logic [7:0] w_in = '0, f_in = '0, lit_in = '0;
    logic [7:0] result;
    logic       dest_is_reg;
    logic [2:0] flag_we;
    logic       stat_z, stat_c, stat_dc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_alu8 i_mcu_alu8 (
        .clk(clk), .rst(rst), .op_sel(op_sel), .use_lit(use_lit),
        .dest_reg(dest_reg), .w_in(w_in), .f_in(f_in), .lit_in(lit_in),
        .result(result), .dest_is_reg(dest_is_reg), .flag_we(flag_we),
        .stat_z(stat_z), .stat_c(stat_c), .stat_dc(stat_dc)
    );

    // efl packs expected flags after the edge as {DC, C, Z}.
    typedef struct packed {
        logic [3:0] req;
        logic [3:0] op;
        logic       lit;
        logic       dst;
        logic [7:0] w;
        logic [7:0] f;
        logic [7:0] l;
        logic [7:0] res;
        logic       edst;
        logic [2:0] efl;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{4'd1,  4'h0, 1'b0, 1'b0, 8'h6C, 8'hF0, 8'h00, 8'h60, 1'b0, 3'b000}, // R1 and
        '{4'd8,  4'h0, 1'b1, 1'b1, 8'h0F, 8'h00, 8'hF0, 8'h00, 1'b0, 3'b001}, // R8 literal forces W
        '{4'd8,  4'h1, 1'b0, 1'b1, 8'h12, 8'h40, 8'h00, 8'h52, 1'b1, 3'b000}, // R8 to register
        '{4'd5,  4'h2, 1'b1, 1'b0, 8'hA5, 8'h00, 8'hA5, 8'h00, 1'b0, 3'b001}, // R5 xor zero
        '{4'd1,  4'h3, 1'b0, 1'b0, 8'h55, 8'hFF, 8'h00, 8'h00, 1'b0, 3'b001}, // R1 complement
        '{4'd2,  4'h4, 1'b0, 1'b0, 8'h26, 8'h1C, 8'h00, 8'h42, 1'b0, 3'b100}, // R2 digit carry
        '{4'd2,  4'h4, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 8'h00, 1'b0, 3'b111}, // R2 full carry
        '{4'd9,  4'h3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 3'b110}, // R9 C,DC kept
        '{4'd3,  4'h5, 1'b0, 1'b0, 8'h1C, 8'h2E, 8'h00, 8'h12, 1'b0, 3'b110}, // R3 no borrow
        '{4'd3,  4'h5, 1'b0, 1'b0, 8'h01, 8'h10, 8'h00, 8'h0F, 1'b0, 3'b010}, // R3 nibble borrow
        '{4'd3,  4'h5, 1'b0, 1'b0, 8'h06, 8'h05, 8'h00, 8'hFF, 1'b0, 3'b000}, // R3 borrow
        '{4'd3,  4'h5, 1'b0, 1'b0, 8'h33, 8'h33, 8'h00, 8'h00, 1'b0, 3'b111}, // R3 equal
        '{4'd4,  4'h6, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 3'b111}, // R4 inc wrap
        '{4'd4,  4'h7, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 3'b110}, // R4 dec wrap
        '{4'd6,  4'h8, 1'b0, 1'b0, 8'h00, 8'h80, 8'h00, 8'h01, 1'b0, 3'b110}, // R6 rlc c=1
        '{4'd6,  4'h8, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 8'h03, 1'b0, 3'b100}, // R6 rlc out 0
        '{4'd6,  4'h9, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 3'b110}, // R6 rrc, Z kept
        '{4'd6,  4'h9, 1'b0, 1'b0, 8'h00, 8'h02, 8'h00, 8'h81, 1'b0, 3'b100}, // R6 rrc c=1
        '{4'd7,  4'hA, 1'b0, 1'b1, 8'h00, 8'hA5, 8'h00, 8'h5A, 1'b1, 3'b100}, // R7 swap
        '{4'd4,  4'h6, 1'b0, 1'b0, 8'h00, 8'h7F, 8'h00, 8'h80, 1'b0, 3'b100}, // R4 inc
        '{4'd5,  4'h7, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 3'b101}, // R5 dec to zero
        '{4'd11, 4'hC, 1'b0, 1'b1, 8'h00, 8'h3C, 8'h00, 8'h3C, 1'b1, 3'b101}, // R11 reserved
        '{4'd8,  4'h4, 1'b1, 1'b1, 8'h08, 8'h00, 8'h08, 8'h10, 1'b0, 3'b100}  // R8 literal add
    };

    function automatic logic [2:0] exp_we(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd7: return 3'b001;
            4'd4, 4'd5:                         return 3'b111;
            4'd8, 4'd9:                         return 3'b010;
            default:                            return 3'b000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 reset flags", {5'd0, stat_dc, stat_c, stat_z}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            string tag;
            v = TBL[i];
            tag = $sformatf("R%0d row %0d", v.req, i);
            op_sel = v.op; use_lit = v.lit; dest_reg = v.dst;
            w_in = v.w; f_in = v.f; lit_in = v.l;
            #1;
            check({tag, " result"}, result, v.res);
            check({tag, " dest"}, {7'd0, dest_is_reg}, {7'd0, v.edst});
            // R9 enable encoding
            check({tag, " R9 flag_we"}, {5'd0, flag_we}, {5'd0, exp_we(v.op)});
            @(negedge clk);
            check({tag, " flags"}, {5'd0, stat_dc, stat_c, stat_z}, {5'd0, v.efl});
        end

        // R10: reset beats a flag-setting add in the same cycle
        op_sel = 4'h4; use_lit = 1'b0; dest_reg = 1'b0; w_in = 8'hFF; f_in = 8'h01;
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset over add", {5'd0, stat_dc, stat_c, stat_z}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after release", {5'd0, stat_dc, stat_c, stat_z}, 8'h07);

        finish_run();
    end
endmodule